// File: doc/BRIEF.md
# Two-Tank Batch Mixing Controller

This block sequences a small batch plant. Two liquids are dosed at the same time, one into each of two holding tanks. Each tank is then emptied into a reactor vat, the vat contents are mixed, and the product is discharged into containers. The controller is hierarchical. A top-level phase machine steps through idle, dosing, mixing and discharge. The dosing phase is a composite state that holds one sub-machine per tank, and these run concurrently. Each sub-machine fills its tank and then empties it.

Two classes of exception sit above the phase machine. A defect command freezes the process. All actuators drop, and the state of the phase machine and of both dosing sub-machines is held. A resume command continues from exactly where the process stopped. A failure command is critical. It preempts everything, opens the emergency dump path and raises an emergency flag. Only a synchronous reset leaves this state.

All inputs are sampled on the rising clock edge. Every output is decoded from registered state, so a change seen at one edge shows on the outputs after that edge.

Top module: `mixctl_top`

## Requirements
- R1: During and right after a synchronous reset, all six actuator bits, `drain_open` and `emerg` are 0 and the controller is idle.
- R2: `start` is accepted only while idle. A start pulse during any other phase leaves the outputs and the phase unchanged.
- R3: Accepting a start enters dosing. Both tank inlets open together on the next cycle: `act[0]` for tank A and `act[1]` for tank B.
- R4: Each dosing region fills until its full sensor is seen (`sens[0]` for A, `sens[1]` for B). It then empties its tank into the reactor (`act[2]` for A, `act[3]` for B) until its empty sensor is seen (`sens[2]` for A, `sens[3]` for B). After that the region is done.
- R5: The controller leaves dosing only after both regions are done. The mixer `act[4]` then runs. `sens[4]` has no effect before mixing starts.
- R6: The mixer runs until `sens[4]`. Discharge then drives `act[5]` and `drain_open` until `sens[5]`, after which the controller is idle with all outputs 0.
- R7: A defect during dosing, mixing or discharge freezes the process. While frozen, all actuator bits and `drain_open` are 0 and sensors are ignored. A resume restores the exact region and phase outputs held before the freeze.
- R8: A defect while idle is ignored. The controller stays idle and accepts a later start.
- R9: A failure in any state enters emergency: `emerg`=1, `drain_open`=1, all actuator bits 0. Emergency persists through start, resume and defect.
- R10: Failure wins over defect and over resume in the same cycle, and it is accepted while frozen.
- R11: A synchronous reset is the only exit from emergency, and it returns the controller to idle.
- R12: Under any interleaving of sensors and commands, the outputs change only as a result of the inputs sampled at the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a batch (idle only) |
| defect | input | 1 | Resumable freeze command |
| resume | input | 1 | Continue after a freeze |
| failure | input | 1 | Critical fault, non-resumable |
| sens | input | 6 | Plant sensors: full A, full B, empty A, empty B, mix done, reactor empty |
| act | output | 6 | Actuators: fill A, fill B, empty A, empty B, mixer, discharge |
| drain_open | output | 1 | Drain valve, open during discharge and in emergency |
| emerg | output | 1 | Emergency state flag |

## Verification
The embedded assertions check several rules on every cycle:
- the stickiness of emergency and its output pattern;
- the zeroed outputs and held state while frozen;
- that a failure is always taken on the next cycle;
- that a region never skips from filling to emptying without its full sensor;
- that dosing never hands over to mixing before both regions are done;
- that start never re-enters dosing from a later phase.

Only the bench scenarios can show the other behaviours. These are the exact actuator code at each step of a batch, that a resumed process continues with the same region outputs it had before the freeze, that a defect while idle is ignored, and agreement with a cycle-level model under long mixed sequences of sensors, freezes and faults.

// File: rtl/mixctl_pkg.sv
package mixctl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DOSE  = 2'd1,
        PH_MIX   = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        LEG_OFF   = 2'd0,
        LEG_FILL  = 2'd1,
        LEG_EMPTY = 2'd2,
        LEG_DONE  = 2'd3
    } leg_e;

    typedef enum logic [1:0] {
        EX_RUN    = 2'd0,
        EX_FROZEN = 2'd1,
        EX_HALT   = 2'd2
    } exc_e;

    typedef struct packed {
        logic fill;
        logic empty;
        logic done;
    } leg_out_t;

    // Next state of one dosing region when it is not held.
    function automatic leg_e leg_next(leg_e s, logic enter, logic full_s, logic empty_s);
        leg_e n;
        n = s;
        case (s)
            LEG_OFF:   if (enter)   n = LEG_FILL;
            LEG_FILL:  if (full_s)  n = LEG_EMPTY;
            LEG_EMPTY: if (empty_s) n = LEG_DONE;
            default:   n = s;
        endcase
        return n;
    endfunction

    // Next exception mode; failure outranks every other command.
    function automatic exc_e exc_next(exc_e m, logic defect, logic resume,
                                      logic failure, logic active);
        exc_e n;
        n = m;
        case (m)
            EX_RUN: begin
                if (failure)               n = EX_HALT;
                else if (defect && active) n = EX_FROZEN;
            end
            EX_FROZEN: begin
                if (failure)     n = EX_HALT;
                else if (resume) n = EX_RUN;
            end
            default: n = EX_HALT;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mixctl_dose_leg.sv
module mixctl_dose_leg
    import mixctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enter,
    input  logic     clear,
    input  logic     hold,
    input  logic     full_s,
    input  logic     empty_s,
    output leg_out_t leg_o
);

    leg_e st_q;
    leg_e st_d;

    // The held register doubles as the history of this region.
    always_comb begin
        st_d = st_q;
        if (!hold) begin
            if (clear) st_d = LEG_OFF;
            else       st_d = leg_next(st_q, enter, full_s, empty_s);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LEG_OFF;
        else     st_q <= st_d;
    end

    assign leg_o.fill  = (st_q == LEG_FILL);
    assign leg_o.empty = (st_q == LEG_EMPTY);
    assign leg_o.done  = (st_q == LEG_DONE);

    // R4
    fill_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LEG_FILL && !full_s) |=> (st_q != LEG_EMPTY));

    // R4
    empty_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == LEG_EMPTY && !empty_s) |=> (st_q != LEG_DONE));

    // R7
    leg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(st_q));

endmodule

// File: rtl/mixctl_exc_unit.sv
module mixctl_exc_unit
    import mixctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic defect,
    input  logic resume,
    input  logic failure,
    input  logic active,
    output exc_e mode
);

    exc_e md_q;

    always_ff @(posedge clk) begin
        if (rst) md_q <= EX_RUN;
        else     md_q <= exc_next(md_q, defect, resume, failure, active);
    end

    assign mode = md_q;

    // R10
    fail_take_chk: assert property (@(posedge clk) disable iff (rst)
        failure |=> (md_q == EX_HALT));

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (md_q == EX_HALT) |=> (md_q == EX_HALT));

    // R8
    idle_defect_chk: assert property (@(posedge clk) disable iff (rst)
        (md_q == EX_RUN && !failure && !active) |=> (md_q == EX_RUN));

endmodule

// File: rtl/mixctl_top.sv
module mixctl_top
    import mixctl_pkg::*;
#(
    parameter int NUM_LEGS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    defect,
    input  logic                    resume,
    input  logic                    failure,
    input  logic [2*NUM_LEGS+1:0]   sens,
    output logic [2*NUM_LEGS+1:0]   act,
    output logic                    drain_open,
    output logic                    emerg
);

    localparam int NUM_IO    = 2*NUM_LEGS + 2;
    localparam int MIX_DONE  = 2*NUM_LEGS;
    localparam int VAT_EMPTY = 2*NUM_LEGS + 1;

    phase_e          phase_q;
    phase_e          phase_d;
    exc_e            mode;
    leg_out_t        legs [NUM_LEGS];
    logic [NUM_LEGS-1:0] done_v;
    logic            all_done;
    logic            active;
    logic            hold;
    logic            run;
    logic            halt;
    logic            leg_enter;
    logic            leg_clear;

    assign active   = (phase_q != PH_IDLE);
    assign hold     = (mode != EX_RUN) | failure | (defect & active);
    assign all_done = &done_v;
    assign run      = (mode == EX_RUN);
    assign halt     = (mode == EX_HALT);

    assign leg_enter = !hold && (phase_q == PH_IDLE) && start;
    assign leg_clear = !hold && (phase_q == PH_DOSE) && all_done;

    mixctl_exc_unit u_exc (
        .clk     (clk),
        .rst     (rst),
        .defect  (defect),
        .resume  (resume),
        .failure (failure),
        .active  (active),
        .mode    (mode)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        mixctl_dose_leg u_leg (
            .clk     (clk),
            .rst     (rst),
            .enter   (leg_enter),
            .clear   (leg_clear),
            .hold    (hold),
            .full_s  (sens[g]),
            .empty_s (sens[NUM_LEGS+g]),
            .leg_o   (legs[g])
        );
        assign done_v[g]          = legs[g].done;
        assign act[g]             = run & legs[g].fill;
        assign act[NUM_LEGS+g]    = run & legs[g].empty;
    end

    always_comb begin
        phase_d = phase_q;
        if (!hold) begin
            case (phase_q)
                PH_IDLE:  if (start)           phase_d = PH_DOSE;
                PH_DOSE:  if (all_done)        phase_d = PH_MIX;
                PH_MIX:   if (sens[MIX_DONE])  phase_d = PH_DRAIN;
                PH_DRAIN: if (sens[VAT_EMPTY]) phase_d = PH_IDLE;
                default:                       phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign act[MIX_DONE]  = run & (phase_q == PH_MIX);
    assign act[VAT_EMPTY] = run & (phase_q == PH_DRAIN);
    assign drain_open     = (run & (phase_q == PH_DRAIN)) | halt;
    assign emerg          = halt;

    // R5
    dose_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DOSE && !all_done) |=> (phase_q != PH_MIX));

    // R2
    late_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (phase_q == PH_MIX || phase_q == PH_DRAIN)) |=> (phase_q != PH_DOSE));

    // R7
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EX_FROZEN) |-> (act == '0 && !drain_open));

    // R7
    frozen_hist_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EX_FROZEN && !resume && !failure) |=> $stable(phase_q));

    // R9
    halt_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == EX_HALT) |-> (act == '0 && drain_open && emerg));

    // R3
    enter_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && $countones(act) != 0) |-> 1'b0);

    initial begin
        io_width_chk: assert (NUM_IO == $bits(act));
    end

endmodule

// File: tb/mixctl_top_tb_top.sv
module mixctl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       defect = 1'b0;
    logic       resume = 1'b0;
    logic       failure = 1'b0;
    logic [5:0] sens = '0;
    logic [5:0] act;
    logic       drain_open;
    logic       emerg;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    mixctl_top #(.NUM_LEGS(2)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .defect     (defect),
        .resume     (resume),
        .failure    (failure),
        .sens       (sens),
        .act        (act),
        .drain_open (drain_open),
        .emerg      (emerg)
    );

    // Reference model state: phase 0..3, region 0..3 each, mode 0 run/1 frozen/2 halt
    int m_ph;
    int m_r0;
    int m_r1;
    int m_md;

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [5:0] ea, input logic ed, input logic ee);
        checks++;
        if (act !== ea || drain_open !== ed || emerg !== ee) begin
            fails++;
            $display("FAIL %s act=%b drain=%b emerg=%b expected act=%b drain=%b emerg=%b",
                     tag, act, drain_open, emerg, ea, ed, ee);
        end
    endtask

    function automatic int reg_next(int r, logic f, logic e);
        if (r == 1 && f) return 2;
        if (r == 2 && e) return 3;
        return r;
    endfunction

    task automatic model_step();
        int nph, nr0, nr1, nmd;
        bit act_now, hold;
        if (rst) begin
            m_ph = 0; m_r0 = 0; m_r1 = 0; m_md = 0;
            return;
        end
        act_now = (m_ph != 0);
        hold = (m_md != 0) || failure || (defect && act_now);
        nph = m_ph; nr0 = m_r0; nr1 = m_r1; nmd = m_md;
        if (!hold) begin
            case (m_ph)
                0: if (start) begin nph = 1; nr0 = 1; nr1 = 1; end
                1: if (m_r0 == 3 && m_r1 == 3) begin nph = 2; nr0 = 0; nr1 = 0; end
                   else begin
                       nr0 = reg_next(m_r0, sens[0], sens[2]);
                       nr1 = reg_next(m_r1, sens[1], sens[3]);
                   end
                2: if (sens[4]) nph = 3;
                default: if (sens[5]) nph = 0;
            endcase
        end
        if (m_md != 2) begin
            if (failure) nmd = 2;
            else if (m_md == 0 && defect && act_now) nmd = 1;
            else if (m_md == 1 && resume) nmd = 0;
        end
        m_ph = nph; m_r0 = nr0; m_r1 = nr1; m_md = nmd;
    endtask

    function automatic logic [5:0] model_act();
        logic [5:0] a;
        a = '0;
        if (m_md == 0) begin
            a[0] = (m_r0 == 1);
            a[1] = (m_r1 == 1);
            a[2] = (m_r0 == 2);
            a[3] = (m_r1 == 2);
            a[4] = (m_ph == 2);
            a[5] = (m_ph == 3);
        end
        return a;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        cyc();
        rst = 1'b0;
        chk("R1 reset state", 6'b000000, 1'b0, 1'b0);

        start = 1; cyc(); start = 0;
        chk("R3 both inlets open", 6'b000011, 0, 0);
        sens[0] = 1; cyc(); sens = '0;
        chk("R4 tank A empties after full", 6'b000110, 0, 0);
        sens[2] = 1; sens[4] = 1; cyc(); sens[2] = 0;
        chk("R4 tank A done, B filling", 6'b000010, 0, 0);
        cyc(); sens = '0;
        chk("R5 early mix sensor no effect", 6'b000010, 0, 0);

        defect = 1; cyc(); defect = 0;
        chk("R7 freeze drops outputs", 6'b000000, 0, 0);
        sens[1] = 1; cyc(); sens = '0;
        chk("R7 sensor ignored while frozen", 6'b000000, 0, 0);
        resume = 1; cyc(); resume = 0;
        chk("R7 resume restores region state", 6'b000010, 0, 0);

        sens[1] = 1; cyc(); sens = '0;
        chk("R4 tank B empties", 6'b001000, 0, 0);
        sens[3] = 1; cyc(); sens = '0;
        chk("R5 both done, still dosing", 6'b000000, 0, 0);
        cyc();
        chk("R5 mixer after both done", 6'b010000, 0, 0);
        start = 1; cyc(); start = 0;
        chk("R2 start ignored while mixing", 6'b010000, 0, 0);
        sens[4] = 1; cyc(); sens = '0;
        chk("R6 discharge opens", 6'b100000, 1, 0);
        cyc();
        chk("R6 discharge holds until empty", 6'b100000, 1, 0);
        sens[5] = 1; cyc(); sens = '0;
        chk("R6 back to idle", 6'b000000, 0, 0);

        defect = 1; cyc(); defect = 0;
        start = 1; cyc(); start = 0;
        chk("R8 idle defect ignored", 6'b000011, 0, 0);

        defect = 1; failure = 1; cyc(); defect = 0; failure = 0;
        chk("R10 failure beats defect", 6'b000000, 1, 1);
        resume = 1; start = 1; defect = 1; cyc(); resume = 0; start = 0; defect = 0;
        chk("R9 emergency persists", 6'b000000, 1, 1);
        rst = 1; cyc(); rst = 0;
        chk("R11 reset leaves emergency", 6'b000000, 0, 0);

        start = 1; cyc(); start = 0;
        defect = 1; cyc(); defect = 0;
        failure = 1; resume = 1; cyc(); failure = 0; resume = 0;
        chk("R10 failure while frozen beats resume", 6'b000000, 1, 1);
        rst = 1; cyc(); rst = 0;
        failure = 1; cyc(); failure = 0;
        chk("R9 failure from idle", 6'b000000, 1, 1);

        // Mixed-sequence sweep against the cycle model.
        rst = 1; model_step(); cyc(); rst = 0;
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            sens    = {lf[5] & lf[9], lf[4] & lf[8], lf[3] & lf[7], lf[2] & lf[6],
                       lf[1] & lf[11], lf[0] & lf[12]};
            start   = lf[13] & lf[14];
            defect  = lf[15] & lf[3] & lf[10] & lf[6];
            resume  = lf[2] & lf[7];
            failure = (lf == 16'h5A5A) || ((i % 997) == 996);
            rst     = (m_md == 2) && lf[1] && lf[4];
            model_step();
            cyc();
            rst = 0; start = 0; defect = 0; resume = 0; failure = 0; sens = '0;
            chk("R12 model agreement", model_act(),
                (m_md == 2) || (m_md == 0 && m_ph == 3), m_md == 2);
        end

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule